// File: doc/BRIEF.md
# Linked Transfer Descriptor Engine

This engine follows a chain of 16-byte descriptors in memory for one endpoint direction, transmit or receive. Software sets a start address and pulses a go input. The engine then reads the four little-endian 32-bit words of each descriptor over a simple memory port. It checks the ownership and skip flags, then gives the buffer address and byte length to a data mover through a request/done handshake. After that it writes the status back and moves on through the next pointer. The direction input selects which of the two layouts is decoded. It is held steady while a chain is walked.

A descriptor that software still owns stops the walk. The engine then sits in a parked state. A resume pulse makes it re-read the same descriptor, and a new go pulse moves it to a new chain head. A completion interrupt pulses for each finished descriptor that asks for one. The address of the descriptor in work is always visible on an output. Software must build rings of at least two entries.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the engine is idle: no memory request, no transfer request, interrupt low, parked low and current pointer zero.
- R2: A go pulse loads the start address into the current pointer. The engine then reads the descriptor words at offsets 0, 4, 8 and 12 from it, one at a time, in that order.
- R3: A fetched descriptor with word 0 bit 0 (hardware-own) clear parks the engine at that address. No transfer or write takes place. A resume pulse re-reads that descriptor from word 0.
- R4: A descriptor with hardware-own set and word 0 bit 2 (skip) set gets no transfer, no write-back and no interrupt. The engine goes straight on to its next pointer.
- R5: Transmit layout: the transfer length is word 3 bits 15:0 and the zero-length-packet request is word 3 bit 29. The buffer address is word 0 bits 19:16 above word 2.
- R6: Receive layout: the allowed length is word 0 bits 31:16 and the buffer address is word 3 bits 19:16 above word 2. The zero-length-packet output stays 0 whatever word 3 bit 29 holds.
- R7: The next pointer is the upper extension nibble (bits 23:20 of word 0 for transmit, of word 3 for receive) above word 1.
- R8: On receive, word 3 is written back with bits 15:0 replaced by the received count and the other bits kept. On transmit, word 3 is written back unchanged.
- R9: For each processed descriptor, word 3 is written before word 0. Word 0 is written with bit 0 cleared and all other bits kept.
- R10: The interrupt is a single-cycle pulse after the word 0 write of each processed descriptor with word 0 bit 7 set. It never pulses for other descriptors.
- R11: The current-pointer output holds the address of the descriptor being worked on for the whole of its handling.
- R12: The transfer request, buffer address and length stay steady until transfer done. No memory access happens while a transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Go pulse; accepted when idle or parked |
| start_addr | input | 36 | Chain head address |
| resume | input | 1 | Re-read the parked descriptor |
| dir_tx | input | 1 | 1 = transmit layout, 0 = receive layout |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 36 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| xfer_req | output | 1 | Data movement request |
| xfer_addr | output | 36 | Buffer address |
| xfer_len | output | 16 | Bytes to send or allowed to receive |
| xfer_zlp | output | 1 | Trailing zero-length packet wanted (transmit) |
| xfer_done | input | 1 | Data movement finished |
| xfer_rx_count | input | 16 | Bytes received, valid with xfer_done |
| irq | output | 1 | Completion interrupt pulse |
| cur_ptr | output | 36 | Address of descriptor in work |
| parked | output | 1 | Waiting on a software-owned descriptor |

## Verification
The completion interrupt of one descriptor and the first word read of the next one fall in the same cycle. The interrupt is registered from the word 0 write, and that same edge starts the next fetch. Every chain in the bench ends in a software-owned descriptor, so this overlap is provoked each time an interrupting descriptor finishes. On each interrupt pulse the bench checks that a read is in flight at the new current pointer. It also checks that the pulse count matches the descriptors that asked for one. It checks the same overlap right after a skipped descriptor, where no pulse may appear.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    localparam int WORD_W   = 32;
    localparam int EXT_W    = 4;
    localparam int ADDR_W   = WORD_W + EXT_W;
    localparam int LEN_W    = 16;
    localparam int NWORDS   = 4;
    localparam int IDX_W    = $clog2(NWORDS);
    localparam int BYTES_W  = WORD_W / 8;
    localparam int HWO_BIT  = 0;
    localparam int SKIP_BIT = 2;
    localparam int IOC_BIT  = 7;
    localparam int ZLP_BIT  = 29;
    localparam int EXT_LO   = 16;
    localparam int RXLEN_LO = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_XFER, ST_WB3, ST_WB0, ST_PARK
    } walk_st_e;

    typedef struct packed {
        logic              own;
        logic              skip;
        logic              ioc;
        logic [ADDR_W-1:0] buf_addr;
        logic [ADDR_W-1:0] next_addr;
        logic [LEN_W-1:0]  len;
        logic              zlp;
    } desc_view_t;

    typedef struct packed {
        walk_st_e                        st;
        logic [ADDR_W-1:0]               cur;
        logic [IDX_W-1:0]                widx;
        logic [NWORDS-1:0][WORD_W-1:0]   words;
        logic [LEN_W-1:0]                cnt;
        logic                            irq;
    } walk_regs_t;
endpackage

// File: rtl/dcw_decode.sv
module dcw_decode
    import dcw_pkg::*;
(
    input  logic                          is_tx,
    input  logic [NWORDS-1:0][WORD_W-1:0] words,
    output desc_view_t                    view
);
    logic [2*EXT_W-1:0] ext;

    always_comb begin
        ext            = is_tx ? words[0][EXT_LO +: 2*EXT_W]
                               : words[3][EXT_LO +: 2*EXT_W];
        view.own       = words[0][HWO_BIT];
        view.skip      = words[0][SKIP_BIT];
        view.ioc       = words[0][IOC_BIT];
        view.buf_addr  = {ext[EXT_W-1:0], words[2]};
        view.next_addr = {ext[2*EXT_W-1:EXT_W], words[1]};
        view.len       = is_tx ? words[3][LEN_W-1:0]
                               : words[0][RXLEN_LO +: LEN_W];
        view.zlp       = is_tx & words[3][ZLP_BIT];
    end
endmodule

// File: rtl/dcw_wb_compose.sv
module dcw_wb_compose
    import dcw_pkg::*;
(
    input  logic              is_tx,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w3,
    input  logic [LEN_W-1:0]  cnt,
    output logic [WORD_W-1:0] wb0,
    output logic [WORD_W-1:0] wb3
);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << HWO_BIT;

    always_comb begin
        wb3 = is_tx ? w3 : {w3[WORD_W-1:LEN_W], cnt};
        wb0 = w0 & ~OWN_MASK;
    end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
    import dcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              resume,
    input  logic              dir_tx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_zlp,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_rx_count,
    output logic              irq,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              parked
);
    localparam logic [ADDR_W-1:0] W3_OFS = ADDR_W'((NWORDS - 1) * BYTES_W);

    walk_regs_t        q, d;
    desc_view_t        view;
    logic [WORD_W-1:0] wb0, wb3;

    dcw_decode u_decode (
        .is_tx (dir_tx),
        .words (q.words),
        .view  (view)
    );

    dcw_wb_compose u_wb (
        .is_tx (dir_tx),
        .w0    (q.words[0]),
        .w3    (q.words[3]),
        .cnt   (q.cnt),
        .wb0   (wb0),
        .wb3   (wb3)
    );

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.cur;
        mem_wdata = '0;
        xfer_req  = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_PARK: begin
                if (start) begin
                    d.cur  = start_addr;
                    d.widx = '0;
                    d.st   = ST_FETCH;
                end else if (resume && q.st == ST_PARK) begin
                    d.widx = '0;
                    d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + ADDR_W'({q.widx, 2'b00});
                if (mem_ack) begin
                    d.words[q.widx] = mem_rdata;
                    if (q.widx == IDX_W'(NWORDS - 1)) begin
                        d.st = ST_CHECK;
                    end else begin
                        d.widx = q.widx + 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                d.widx = '0;
                if (!view.own) begin
                    d.st = ST_PARK;
                end else if (view.skip) begin
                    d.cur = view.next_addr;
                    d.st  = ST_FETCH;
                end else begin
                    d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                xfer_req = 1'b1;
                if (xfer_done) begin
                    d.cnt = xfer_rx_count;
                    d.st  = ST_WB3;
                end
            end
            ST_WB3: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur + W3_OFS;
                mem_wdata = wb3;
                if (mem_ack) d.st = ST_WB0;
            end
            ST_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb0;
                if (mem_ack) begin
                    d.irq  = view.ioc;
                    d.cur  = view.next_addr;
                    d.widx = '0;
                    d.st   = ST_FETCH;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign xfer_addr = view.buf_addr;
    assign xfer_len  = view.len;
    assign xfer_zlp  = view.zlp;
    assign irq       = q.irq;
    assign cur_ptr   = q.cur;
    assign parked    = (q.st == ST_PARK);
endmodule

// File: rtl/dcw_chk.sv
module dcw_chk
    import dcw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              xfer_req,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              irq,
    input logic [ADDR_W-1:0] cur_ptr
);
    localparam logic [ADDR_W-1:0] W3_OFS = ADDR_W'((NWORDS - 1) * BYTES_W);

    logic wr_own, wr_len, w3_seen;
    assign wr_own = mem_req && mem_we && mem_addr == cur_ptr;
    assign wr_len = mem_req && mem_we && mem_addr == cur_ptr + W3_OFS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   w3_seen <= 1'b0;
        else if (wr_len && mem_ack)   w3_seen <= 1'b1;
        else if (wr_own && mem_ack)   w3_seen <= 1'b0;
    end

    assert_len_before_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_own |-> w3_seen);
    assert_own_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_own |-> !mem_wdata[HWO_BIT]);
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_we && mem_ack));
    assert_xfer_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));
    assert_xfer_no_mem_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !mem_req);
    assert_ptr_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> $stable(cur_ptr));
endmodule

bind desc_chain_walker dcw_chk u_chk (.*);

// File: tb/desc_chain_walker_tb_top.sv
module desc_chain_walker_tb_top;
    import dcw_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              resume = 1'b0;
    logic              dir_tx = 1'b1;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic              xfer_req, xfer_zlp, irq, parked;
    logic              xfer_done = 1'b0;
    logic [LEN_W-1:0]  xfer_rx_count = '0;
    logic [ADDR_W-1:0] xfer_addr, cur_ptr;
    logic [LEN_W-1:0]  xfer_len;

    always #2 clk = ~clk;

    desc_chain_walker dut_i (.*);

    // memory model: always ready, 64 words
    logic [31:0] mem [64];
    logic        tb_wr = 1'b0, tb_clr = 1'b0;
    logic [5:0]  tb_idx = '0;
    logic [31:0] tb_dat = '0;
    logic [7:0]  rlog [16];
    logic [7:0]  wlog [16];
    int          rcnt, wcnt;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (tb_wr) mem[tb_idx] <= tb_dat;
        else if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (tb_clr) begin
            rcnt <= 0; wcnt <= 0;
        end else if (mem_req && mem_we) begin
            if (wcnt < 16) wlog[wcnt] <= mem_addr[7:0];
            wcnt <= wcnt + 1;
        end else if (mem_req) begin
            if (rcnt < 16) rlog[rcnt] <= mem_addr[7:0];
            rcnt <= rcnt + 1;
        end
    end

    // data mover responder and interrupt monitor
    int                xfer_cnt, irq_cnt, irq_rd_bad, stab_bad, ph, nwait;
    logic [ADDR_W-1:0] rec_addr, rec_cur;
    logic [LEN_W-1:0]  rec_len, rsp_cnt = '0;
    logic              rec_zlp;

    initial begin
        forever begin
            @(negedge clk);
            if (tb_clr) begin
                xfer_cnt = 0; irq_cnt = 0; irq_rd_bad = 0; stab_bad = 0;
                ph = 0; xfer_done = 1'b0;
            end else begin
                if (irq) begin
                    irq_cnt++;
                    if (!(mem_req && !mem_we && mem_addr == cur_ptr)) irq_rd_bad++;
                end
                case (ph)
                    0: if (xfer_req) begin
                        rec_addr = xfer_addr; rec_len = xfer_len;
                        rec_zlp = xfer_zlp; rec_cur = cur_ptr;
                        xfer_cnt++; ph = 1; nwait = 0;
                    end
                    1: begin
                        if (!xfer_req || xfer_addr != rec_addr || xfer_len != rec_len
                            || cur_ptr != rec_cur) stab_bad++;
                        nwait++;
                        if (nwait == 3) begin
                            xfer_done = 1'b1; xfer_rx_count = rsp_cnt; ph = 2;
                        end
                    end
                    default: begin
                        xfer_done = 1'b0; ph = 0;
                    end
                endcase
            end
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(input int idx, input logic [31:0] dat);
        @(negedge clk);
        tb_wr = 1'b1; tb_idx = 6'(idx); tb_dat = dat;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic clr_logs();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk);
        @(negedge clk); tb_clr = 1'b0;
    endtask

    task automatic wait_park();
        for (int i = 0; i < 400 && !parked; i++) @(negedge clk);
    endtask

    task automatic go(input logic [ADDR_W-1:0] a);
        @(negedge clk); start = 1'b1; start_addr = a;
        @(negedge clk); start = 1'b0;
        wait_park();
    endtask

    typedef struct packed {
        logic              tx;
        logic [31:0]       w0, w1, w2, w3;
        logic [15:0]       cnt;
        logic [35:0]       eaddr;
        logic [15:0]       elen;
        logic              ezlp;
        logic [31:0]       ew3, ew0;
        logic              eirq;
        logic [35:0]       enext;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b1, 32'h0052_0081, 32'h50, 32'h1000_0000, 32'h2000_0040, 16'h0,
          36'h2_1000_0000, 16'h0040, 1'b1, 32'h2000_0040, 32'h0052_0080, 1'b1, 36'h5_0000_0050},
        '{1'b1, 32'h0000_0001, 32'h50, 32'h2000_0010, 32'h0000_0200, 16'h0,
          36'h0_2000_0010, 16'h0200, 1'b0, 32'h0000_0200, 32'h0000_0000, 1'b0, 36'h50},
        '{1'b0, 32'h0100_0081, 32'h50, 32'h3000_0000, 32'h2031_FFFF, 16'h0077,
          36'h1_3000_0000, 16'h0100, 1'b0, 32'h2031_0077, 32'h0100_0080, 1'b1, 36'h3_0000_0050},
        '{1'b0, 32'h0040_0001, 32'h50, 32'h0000_0004, 32'h0000_0000, 16'h0040,
          36'h4, 16'h0040, 1'b0, 32'h0000_0040, 32'h0040_0000, 1'b0, 36'h50}
    };

    task automatic run_all();
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mem_req && !xfer_req && !irq && !parked && cur_ptr == '0, "R1 reset",
            {mem_req, xfer_req, irq, parked}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && cur_ptr == '0, "R1 idle after reset", {mem_req, cur_ptr}, 0);

        // table walk: one descriptor at 0x40, a software-owned one at 0x50
        for (int v = 0; v < 4; v++) begin
            dir_tx = VECS[v].tx;
            rsp_cnt = VECS[v].cnt;
            wr_word(16, VECS[v].w0);
            wr_word(17, VECS[v].w1);
            wr_word(18, VECS[v].w2);
            wr_word(19, VECS[v].w3);
            wr_word(20, 32'h0);
            clr_logs();
            go(36'h40);
            repeat (2) @(negedge clk);
            chk(rlog[0] == 8'h40 && rlog[1] == 8'h44 && rlog[2] == 8'h48 && rlog[3] == 8'h4C,
                "R2 fetch order", {rlog[0], rlog[1], rlog[2], rlog[3]}, 32'h4044_484C);
            chk(xfer_cnt == 1 && rec_addr == VECS[v].eaddr,
                VECS[v].tx ? "R5 tx buffer addr" : "R6 rx buffer addr", rec_addr, VECS[v].eaddr);
            chk(rec_len == VECS[v].elen && rec_zlp == VECS[v].ezlp,
                VECS[v].tx ? "R5 tx len/zlp" : "R6 rx len/zlp",
                {rec_len, rec_zlp}, {VECS[v].elen, VECS[v].ezlp});
            chk(mem[19] == VECS[v].ew3, "R8 word3 writeback", mem[19], VECS[v].ew3);
            chk(mem[16] == VECS[v].ew0, "R9 word0 own cleared", mem[16], VECS[v].ew0);
            chk(wcnt == 2 && wlog[0] == 8'h4C && wlog[1] == 8'h40, "R9 write order",
                {wcnt[7:0], wlog[0], wlog[1]}, 24'h02_4C40);
            chk(parked && cur_ptr == VECS[v].enext && rcnt == 8, "R7 next pointer / R3 park",
                cur_ptr, VECS[v].enext);
            chk(irq_cnt == int'(VECS[v].eirq) && irq_rd_bad == 0, "R10 irq pulse with next read",
                {irq_cnt[7:0], irq_rd_bad[7:0]}, {7'h0, VECS[v].eirq, 8'h0});
            chk(rec_cur == 36'h40 && stab_bad == 0, "R11 R12 pointer and request steady",
                {rec_cur, stab_bad[7:0]}, {36'h40, 8'h0});
        end

        // R4: skipped descriptor at 0x40, real one at 0x60, owned-by-software at 0x50
        dir_tx = 1'b1;
        wr_word(16, 32'h0000_0085); wr_word(17, 32'h60);
        wr_word(18, 32'h0000_DEAD); wr_word(19, 32'h10);
        wr_word(24, 32'h0000_0081); wr_word(25, 32'h50);
        wr_word(26, 32'h0000_0700); wr_word(27, 32'h8);
        wr_word(20, 32'h0);
        clr_logs();
        go(36'h40);
        repeat (2) @(negedge clk);
        chk(xfer_cnt == 1 && rec_addr == 36'h700, "R4 skip moves no data",
            {xfer_cnt[7:0], rec_addr}, {8'h1, 36'h700});
        chk(mem[16] == 32'h85 && wcnt == 2 && wlog[0] == 8'h6C && wlog[1] == 8'h60,
            "R4 skip writes nothing", {mem[16], wlog[0], wlog[1]}, {32'h85, 16'h6C60});
        chk(irq_cnt == 1 && irq_rd_bad == 0 && cur_ptr == 36'h50, "R4 R10 skip no irq",
            {irq_cnt[7:0], cur_ptr}, {8'h1, 36'h50});

        // R3: skip flag with own clear parks; no transfer, no write
        wr_word(16, 32'h0000_0004);
        clr_logs();
        go(36'h40);
        repeat (2) @(negedge clk);
        chk(parked && cur_ptr == 36'h40 && xfer_cnt == 0 && wcnt == 0, "R3 park on own clear",
            {parked, xfer_cnt[7:0], wcnt[7:0]}, {1'b1, 16'h0});

        // R3: resume re-reads the same descriptor after software hands it over
        wr_word(16, 32'h0000_0081); wr_word(17, 32'h50);
        wr_word(18, 32'h0000_0900); wr_word(19, 32'h4);
        clr_logs();
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        wait_park();
        repeat (2) @(negedge clk);
        chk(rlog[0] == 8'h40 && xfer_cnt == 1 && rec_addr == 36'h900, "R3 resume refetch",
            {rlog[0], rec_addr}, {8'h40, 36'h900});
        chk(irq_cnt == 1 && cur_ptr == 36'h50 && parked, "R3 R10 resume completes",
            {irq_cnt[7:0], cur_ptr}, {8'h1, 36'h50});
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog all actual=hung expected=finished");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule